// File: doc/BRIEF.md
# Word-Aligned Branch Next-Address Unit

This unit holds the program counter of a 32-bit instruction stream in which every instruction sits on a four-byte boundary. The two low address bits are always zero, so the register stores only the upper word index. The fetch address is that index with two zero bits appended. Each cycle the unit works out the following word index from the current one, a 16-bit branch displacement, a branch-instruction flag and the zero flag of the ALU compare.

A single word-wide adder does both kinds of step. Its carry-in is tied high, which supplies the one-word increment. Its second operand is the sign-extended displacement when a branch is taken, and zero otherwise. A branch is taken only when the branch flag and the zero flag are both high. An advance input lets a pipeline stall freeze the counter. A synchronous reset loads a word-aligned start address, set by a parameter.

Top module: `branch_next_addr`

## Requirements
- R1: `fetchAddr` always equals `pcWord` followed by two zero bits, so `fetchAddr[1:0]` is 2'b00.
- R2: While `rst` is high at a rising clock edge, the counter loads `RESET_ADDR` whatever the other inputs are. The default is 32'h0000_0100, and it must have its two low bits clear. In the cycle after reset is released, `fetchAddr` equals `RESET_ADDR`.
- R3: When `advance` is high and the branch is not taken, the fetch address grows by 4 at the edge. This applies when `isBranch` is 0, whatever `aluZero` is, and when `isBranch` is 1 with `aluZero` 0.
- R4: When `advance`, `isBranch` and `aluZero` are all high, the new fetch address is the old one plus 4 plus four times the signed 16-bit `branchImm`.
- R5: `branchImm` is treated as two's complement, with bit 15 as the sign. A value of 16'hFFFF branches to the branch's own address, and 16'h8000 moves back 0x20000 bytes from the next sequential address.
- R6: When `advance` is low and `rst` is low, the counter keeps its value at the edge, whatever the branch inputs are.
- R7: Address arithmetic wraps modulo 2^32 in byte terms. For example, 32'hFFFF_FFFC followed by a sequential step gives 32'h0000_0000, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Update enable; low holds the counter |
| isBranch | input | 1 | Current instruction is a conditional branch |
| aluZero | input | 1 | Compare result of the two sources was zero |
| branchImm | input | 16 | Signed word displacement of the branch |
| pcWord | output | 30 | Current word index (address bits 31:2) |
| fetchAddr | output | 32 | Byte address for instruction fetch |

## Verification
The hardest case to reach from the ports is the wrap at the top of the address space. Starting from the reset address, only a large sequential run or a backward branch past address zero gets there. The stimulus therefore takes a taken branch with displacement 16'hFFC2 from 0xF0, which lands on 32'hFFFF_FFFC. The next sequential step is then checked for zero. The vector table also pairs each flag combination with a displacement that would be visible if it were wrongly applied, so a non-taken branch that added its offset shows up.

// File: rtl/bna_pkg.sv
package bna_pkg;
  typedef struct packed {
    logic loadPc;
    logic takeBranch;
    logic forceReset;
  } bnaStrobes_t;
endpackage

// File: rtl/bna_control.sv
module bna_control
  import bna_pkg::*;
(
  input  logic        rst,
  input  logic        advance,
  input  logic        isBranch,
  input  logic        aluZero,
  output bnaStrobes_t strobes
);
  always_comb begin
    strobes            = '0;
    strobes.forceReset = rst;
    strobes.loadPc     = advance & ~rst;
    strobes.takeBranch = isBranch & aluZero;
  end
endmodule

// File: rtl/bna_datapath.sv
module bna_datapath
  import bna_pkg::*;
#(
  parameter int          WORD_W     = 30,
  parameter int          IMM_W      = 16,
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  bnaStrobes_t       strobes,
  input  logic [IMM_W-1:0]  branchImm,
  output logic [WORD_W-1:0] pcWord
);
  localparam int EXT_W = WORD_W - IMM_W;

  logic [WORD_W-1:0] extImm;
  logic [WORD_W-1:0] addOperand;
  logic [WORD_W-1:0] nextWord;

  // Sign extension of the word displacement
  generate
    if (EXT_W > 0) begin : g_ext
      assign extImm = {{EXT_W{branchImm[IMM_W-1]}}, branchImm};
    end else begin : g_trunc
      assign extImm = branchImm[WORD_W-1:0];
    end
  endgenerate

  // One adder: carry-in of one gives the increment, operand gives the offset
  assign addOperand = strobes.takeBranch ? extImm : '0;
  assign nextWord   = pcWord + addOperand + WORD_W'(1);

  always_ff @(posedge clk) begin
    if (strobes.forceReset)  pcWord <= RESET_WORD;
    else if (strobes.loadPc) pcWord <= nextWord;
  end

  // R6: counter frozen when not loading
  p_hold_r6: assert property (@(posedge clk) disable iff (strobes.forceReset)
    (!$past(strobes.loadPc) && !$past(strobes.forceReset)) |-> $stable(pcWord));

  // R3: sequential step adds exactly one word
  p_seq_step_r3: assert property (@(posedge clk) disable iff (strobes.forceReset)
    ($past(strobes.loadPc) && !$past(strobes.takeBranch)) |-> pcWord == $past(pcWord) + WORD_W'(1));

  // R4: taken branch adds displacement plus one word
  p_branch_target_r4: assert property (@(posedge clk) disable iff (strobes.forceReset)
    ($past(strobes.loadPc) && $past(strobes.takeBranch))
      |-> pcWord == $past(pcWord) + $past(extImm) + WORD_W'(1));

  // R7: top word wraps to zero on a sequential step
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (strobes.forceReset)
    ($past(strobes.loadPc) && !$past(strobes.takeBranch) && ($past(pcWord) == '1))
      |-> pcWord == '0);
endmodule

// File: rtl/branch_next_addr.sv
module branch_next_addr
  import bna_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          IMM_W      = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_0100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                advance,
  input  logic                isBranch,
  input  logic                aluZero,
  input  logic [IMM_W-1:0]    branchImm,
  output logic [ADDR_W-3:0]   pcWord,
  output logic [ADDR_W-1:0]   fetchAddr
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] RESET_WORD = RESET_ADDR[ADDR_W-1:2];

  bnaStrobes_t strobes;

  bna_control u_control (
    .rst      (rst),
    .advance  (advance),
    .isBranch (isBranch),
    .aluZero  (aluZero),
    .strobes  (strobes)
  );

  bna_datapath #(
    .WORD_W     (WORD_W),
    .IMM_W      (IMM_W),
    .RESET_WORD (RESET_WORD)
  ) u_datapath (
    .clk       (clk),
    .strobes   (strobes),
    .branchImm (branchImm),
    .pcWord    (pcWord)
  );

  assign fetchAddr = {pcWord, 2'b00};

  // R2: reset vector must be word aligned
  initial begin
    p_reset_aligned_r2: assert (RESET_ADDR[1:0] == 2'b00);
  end

  // R2: first cycle out of reset shows the reset address
  p_reset_addr_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> fetchAddr == RESET_ADDR);

  // R1: fetch address tracks the word counter
  p_fetch_word_r1: assert property (@(posedge clk) disable iff (rst)
    fetchAddr[ADDR_W-1:2] == pcWord);
endmodule

// File: tb/branch_next_addr_bench.sv
module branch_next_addr_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        advance;
  logic        isBranch;
  logic        aluZero;
  logic [15:0] branchImm;
  logic [29:0] pcWord;
  logic [31:0] fetchAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  branch_next_addr u_branch_next_addr (
    .clk(clk), .rst(rst), .advance(advance), .isBranch(isBranch),
    .aluZero(aluZero), .branchImm(branchImm), .pcWord(pcWord), .fetchAddr(fetchAddr)
  );

  // {advance, isBranch, aluZero, branchImm}
  localparam logic [18:0] VEC [0:11] = '{
    {3'b100, 16'h0010}, {3'b101, 16'h7FFF}, {3'b110, 16'h0020}, {3'b111, 16'h0004},
    {3'b111, 16'hFFFF}, {3'b111, 16'hFFF0}, {3'b011, 16'h0100}, {3'b000, 16'h0040},
    {3'b111, 16'h7FFF}, {3'b111, 16'h8000}, {3'b100, 16'h1234}, {3'b111, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAlign(input string req);
    check(req, {fetchAddr[1:0] == 2'b00 && fetchAddr[31:2] == pcWord, 31'd0}, {1'b1, 31'd0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] model;
    rst = 1'b1; advance = 1'b0; isBranch = 1'b1; aluZero = 1'b1; branchImm = 16'h0044;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset address visible with advance low and branch inputs active
    check("R2 reset address", fetchAddr, 32'h0000_0100);
    checkAlign("R1 after reset");
    model = 32'h0000_0100;

    for (int i = 0; i < 12; i++) begin
      logic take;
      string req;
      {advance, isBranch, aluZero, branchImm} = VEC[i];
      take = advance & isBranch & aluZero;
      if (!advance) req = "R6 hold";
      else if (take && branchImm[15]) req = "R5 negative offset";
      else if (take) req = "R4 taken branch";
      else req = "R3 sequential";
      @(negedge clk);
      if (advance) model = take ? model + 32'd4 + {{14{VEC[i][15]}}, VEC[i][15:0], 2'b00}
                                : model + 32'd4;
      check(req, fetchAddr, model);
      checkAlign("R1 vector");
    end

    // R5 R7: backward branch past zero lands at top of space (from 0xF0)
    advance = 1'b1; isBranch = 1'b1; aluZero = 1'b1; branchImm = 16'hFFC2;
    @(negedge clk);
    check("R5 wrap-under branch", fetchAddr, 32'hFFFF_FFFC);
    isBranch = 1'b0; aluZero = 1'b0;
    @(negedge clk);
    check("R7 wrap to zero", fetchAddr, 32'h0000_0000);
    checkAlign("R1 at zero");

    // R2: mid-run reset with advance low
    rst = 1'b1; advance = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R2 mid-run reset", fetchAddr, 32'h0000_0100);
    // R6: stays put while advance low
    isBranch = 1'b1; aluZero = 1'b1; branchImm = 16'h0008;
    @(negedge clk);
    check("R6 hold after reset", fetchAddr, 32'h0000_0100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule